// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns eight general-purpose external pins and one dedicated non-maskable pin into interrupt requests. Each line is configured on its own through a small register port:
- whether it is edge or level triggered;
- which polarity it reacts to;
- whether a spike filter sits in front of detection;
- whether detection is enabled at all;
- whether the line only wakes the system instead of recording an interrupt;
- whether an asynchronous wake path is active.

Detected events latch into a status register. Software clears them by writing ones. Each general line's request is its status bit gated by a per-line mask. The ninth line drives a separate non-maskable request that no mask can block.

The asynchronous path compares the raw pin with its polarity using gates only. It can therefore raise the wake output while the block's clock is stopped, so external sleep logic can restart that clock.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every readable register returns zero, and `irq`, `nmi` and `wake` are low.
- R2: Writing ones to address 0 sets mask bits and writing ones to address 1 clears them. Address 2 reads the mask in bits 7:0, and bit 8 always reads 0 because the non-maskable line has no mask.
- R3: Each `irq[i]` is high exactly when status bit i (read at address 3) and mask bit i are both set.
- R4: In edge mode (address 8 bit = 0), polarity 1 (address 9) detects a low-to-high transition of the filtered pin and polarity 0 detects a high-to-low transition. A transition in the other direction sets nothing.
- R5: In level mode (address 8 bit = 1) the status bit is set on every cycle while the pin equals its polarity, so a clear has no lasting effect until the level goes away.
- R6: Writing ones to address 4 clears the matching status bits. When a clear and a new event hit the same line in the same cycle, the status bit stays set.
- R7: With the filter bit set (address 10), a synchronized pin level must differ from the accepted level for 3 consecutive clock samples before it is accepted. A 2-cycle pulse is rejected and a 5-cycle pulse is accepted.
- R8: Writing ones to address 5 enables detection per line and writing ones to address 6 disables it; address 7 reads the enabled set. A disabled line never sets its status bit.
- R9: A line with its wake-only bit set (address 12) never sets its status bit or request. Instead, each detected event drives `wake` high for one cycle.
- R10: A line that is enabled and has its asynchronous bit set (address 11) drives `wake` high combinationally while its raw pin equals its polarity, with no clock edge needed. Such a line bypasses the filter.
- R11: Line 8 takes its input from `nmi_pin` and is configured with bit 8 of each register. `nmi` equals its status bit, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synchronous clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 9 | Write data, one bit per line |
| reg_rdata | output | 9 | Combinational read data |
| pins_in | input | 8 | General external pins |
| nmi_pin | input | 1 | Non-maskable external pin |
| irq | output | 8 | Per-line interrupt requests |
| nmi | output | 1 | Non-maskable request |
| wake | output | 1 | Wake request to sleep logic |

## Verification
The embedded assertions check the register rules on every cycle:
- the mask set and clear writes;
- a clear taking effect when no event coincides with it;
- a coincident event winning over a clear;
- disabled and wake-only lines never gaining a status bit;
- the filter holding its accepted level before three differing samples;
- an edge event never lasting two cycles.

Only the bench scenarios can show the end-to-end behaviour from pin to request. That covers polarity and mode selection, pulse widths at the filter boundary, the combinational asynchronous wake with no clock edge, routing to the non-maskable output, and the level-mode re-set after a clear.

// File: rtl/extint_pkg.sv
// Package: register addresses shared by the controller and its register file.
package extint_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_MSET  = 4'd0;  // mask set, write ones
    localparam logic [ADDR_W-1:0] A_MCLR  = 4'd1;  // mask clear, write ones
    localparam logic [ADDR_W-1:0] A_MASK  = 4'd2;  // mask, read only
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd3;  // status, read only
    localparam logic [ADDR_W-1:0] A_SCLR  = 4'd4;  // status clear, write ones
    localparam logic [ADDR_W-1:0] A_ENSET = 4'd5;  // detection enable, write ones
    localparam logic [ADDR_W-1:0] A_ENCLR = 4'd6;  // detection disable, write ones
    localparam logic [ADDR_W-1:0] A_ENRD  = 4'd7;  // enabled lines, read only
    localparam logic [ADDR_W-1:0] A_LVL   = 4'd8;  // 1 = level mode, 0 = edge mode
    localparam logic [ADDR_W-1:0] A_POL   = 4'd9;  // 1 = rising/high, 0 = falling/low
    localparam logic [ADDR_W-1:0] A_FILT  = 4'd10; // spike filter on
    localparam logic [ADDR_W-1:0] A_ASY   = 4'd11; // asynchronous wake path on
    localparam logic [ADDR_W-1:0] A_WONLY = 4'd12; // wake only, no status
endpackage

// File: rtl/extint_sync_filt.sv
// Module: extint_sync_filt
// Brings one pin into the clock domain through two flops, then optionally
// filters it. The filter accepts a new level only after FILT_LEN consecutive
// differing samples. Assumes FILT_LEN >= 2.
module extint_sync_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic use_filt,
    output logic acc
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic ff1, ff2, filt_q;
    logic [CW-1:0] cnt;

    // Two-flop synchronizer for the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff1 <= 1'b0;
            ff2 <= 1'b0;
        end else begin
            ff1 <= pin;
            ff2 <= ff1;
        end
    end

    // Spike filter: count consecutive samples that differ from the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            cnt    <= '0;
        end else if (!use_filt || (ff2 == filt_q)) begin
            filt_q <= ff2;
            cnt    <= '0;
        end else if (cnt == LAST) begin
            filt_q <= ff2;
            cnt    <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign acc = use_filt ? filt_q : ff2;

    // R7
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_filt && (filt_q != ff2) && (cnt != LAST)) |=> $stable(filt_q));
endmodule

// File: rtl/extint_detect.sv
// Module: extint_detect
// Turns one line's accepted level into an event pulse (edge mode) or a
// continuous event (level mode). It also forms the clockless wake hit from
// the raw pin. Assumes acc is already synchronous to clk.
module extint_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic raw,
    input  logic lvl,
    input  logic pol,
    input  logic en,
    input  logic asy,
    output logic evt,
    output logic ahit
);
    logic prev;

    // Remember the previous accepted level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= acc;
    end

    // Select the event by mode and polarity.
    always_comb begin
        if (lvl)      evt = (acc == pol);
        else if (pol) evt = acc & ~prev;
        else          evt = ~acc & prev;
    end

    // Clockless path: raw pin against polarity, gated only by enable and the async bit.
    assign ahit = en & asy & (raw == pol);

    // R4
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !lvl) |=> !(evt && !lvl && $stable(pol)));
endmodule

// File: rtl/extint_regs.sv
// Module: extint_regs
// Configuration and status registers for N lines. The top line (index N-1)
// has no mask bit. A status bit is set by an enabled, non-wake-only event
// and cleared by a write of ones; a set in the same cycle wins over the clear.
module extint_regs
    import extint_pkg::*;
#(
    parameter int N = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      evt,
    output logic [N-2:0]      mask,
    output logic [N-1:0]      status,
    output logic [N-1:0]      en,
    output logic [N-1:0]      lvl,
    output logic [N-1:0]      pol,
    output logic [N-1:0]      filt,
    output logic [N-1:0]      asy,
    output logic [N-1:0]      wonly,
    output logic [N-1:0]      rdata
);
    logic [N-1:0] set_v, clr_v;

    assign set_v = evt & en & ~wonly;
    assign clr_v = (we && addr == A_SCLR) ? wdata : '0;

    // Configuration writes and status update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            status <= '0;
            en     <= '0;
            lvl    <= '0;
            pol    <= '0;
            filt   <= '0;
            asy    <= '0;
            wonly  <= '0;
        end else begin
            if (we) begin
                case (addr)
                    A_MSET:  mask  <= mask | wdata[N-2:0];
                    A_MCLR:  mask  <= mask & ~wdata[N-2:0];
                    A_ENSET: en    <= en | wdata;
                    A_ENCLR: en    <= en & ~wdata;
                    A_LVL:   lvl   <= wdata;
                    A_POL:   pol   <= wdata;
                    A_FILT:  filt  <= wdata;
                    A_ASY:   asy   <= wdata;
                    A_WONLY: wonly <= wdata;
                    default: ;
                endcase
            end
            status <= (status & ~clr_v) | set_v;
        end
    end

    // Combinational read mux; write-only addresses read zero.
    always_comb begin
        case (addr)
            A_MASK:  rdata = {1'b0, mask};
            A_STAT:  rdata = status;
            A_ENRD:  rdata = en;
            A_LVL:   rdata = lvl;
            A_POL:   rdata = pol;
            A_FILT:  rdata = filt;
            A_ASY:   rdata = asy;
            A_WONLY: rdata = wonly;
            default: rdata = '0;
        endcase
    end

    // R2
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_MSET) |=> ((mask & $past(wdata[N-2:0])) == $past(wdata[N-2:0])));
    // R2
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_MCLR) |=> ((mask & $past(wdata[N-2:0])) == '0));
    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_SCLR) |=> ((status & $past(wdata & ~set_v)) == '0));
    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((status & $past(set_v)) == $past(set_v)));
    // R8
    dis_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(en)) == '0));
    // R9
    wonly_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & $past(wonly)) == '0));
endmodule

// File: rtl/extint_ctrl.sv
// Module: extint_ctrl
// Top of the external interrupt line controller: NLINES maskable lines plus
// one non-maskable line at index NLINES. Per line it instantiates a
// synchronizer/filter and a detector, shares one register file, and forms the
// irq, nmi and wake outputs. Assumes sleep logic acts on wake outside the block.
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NLINES   = 8,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NLINES:0]   reg_wdata,
    output logic [NLINES:0]   reg_rdata,
    input  logic [NLINES-1:0] pins_in,
    input  logic              nmi_pin,
    output logic [NLINES-1:0] irq,
    output logic              nmi,
    output logic              wake
);
    localparam int N = NLINES + 1;

    logic [N-1:0] lines, acc, evt, ahit;
    logic [N-1:0] status, en, lvl, pol, filt, asy, wonly;
    logic [N-2:0] mask;
    logic         wake_q;

    assign lines = {nmi_pin, pins_in};

    // One synchronizer/filter and detector per line.
    for (genvar i = 0; i < N; i++) begin : g_line
        extint_sync_filt #(.FILT_LEN(FILT_LEN)) i_sf (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (lines[i]),
            .use_filt (filt[i] & ~asy[i]),
            .acc      (acc[i])
        );
        extint_detect i_det (
            .clk   (clk),
            .rst_n (rst_n),
            .acc   (acc[i]),
            .raw   (lines[i]),
            .lvl   (lvl[i]),
            .pol   (pol[i]),
            .en    (en[i]),
            .asy   (asy[i]),
            .evt   (evt[i]),
            .ahit  (ahit[i])
        );
    end

    extint_regs #(.N(N)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .evt    (evt),
        .mask   (mask),
        .status (status),
        .en     (en),
        .lvl    (lvl),
        .pol    (pol),
        .filt   (filt),
        .asy    (asy),
        .wonly  (wonly),
        .rdata  (reg_rdata)
    );

    // One-cycle wake pulse from enabled wake-only events.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= |(evt & en & wonly);
    end

    assign irq  = status[N-2:0] & mask;
    assign nmi  = status[N-1];
    assign wake = (|ahit) | wake_q;

    // R9
    wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !(|ahit)) |-> ($past(wonly) != '0));
endmodule

// File: tb/test_extint_ctrl.sv
module test_extint_ctrl;
    localparam int NL = 8;
    localparam int NW = NL + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [NW-1:0] reg_wdata = '0;
    logic [NW-1:0] reg_rdata;
    logic [NL-1:0] pins_in = '0;
    logic          nmi_pin = 1'b0;
    logic [NL-1:0] irq;
    logic          nmi, wake;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [NW-1:0] m_lvl = '0, m_pol = '0;
    logic [NL-1:0] m_mask = '0;

    always #10 clk = ~clk;

    extint_ctrl i_extint_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pins_in(pins_in),
        .nmi_pin(nmi_pin), .irq(irq), .nmi(nmi), .wake(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [NW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [NW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_stat(input bit lv, input bit pl, input bit o, input bit n);
        if (lv) return (o == pl) || (n == pl);
        return pl ? (!o && n) : (o && !n);
    endfunction

    task automatic clear_cfg();
        for (int a = 8; a <= 12; a++) wr(a[3:0], '0);
        wr(4'd1, '1); wr(4'd6, '1);
        pins_in = '0; nmi_pin = 1'b0;
        cyc(6);
        wr(4'd4, '1);
        m_lvl = '0; m_pol = '0; m_mask = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0] d;
        bit seen;
        void'($urandom(32'd20240607));
        cyc(3);
        #1;
        // R1: reset state
        for (int a = 0; a <= 12; a++) begin
            rd(a[3:0], d);
            chk($sformatf("R1 reg %0d at reset", a), d, 0);
        end
        chk("R1 irq/nmi/wake in reset", {irq, nmi, wake}, 0);
        @(negedge clk); rst_n = 1'b1;
        cyc(2);
        chk("R1 outputs after reset", {irq, nmi, wake}, 0);

        // R2: mask set/clear, NMI bit never masked
        wr(4'd0, 9'h1A5);
        rd(4'd2, d); chk("R2 mask after set", d, 9'h0A5);
        wr(4'd1, 9'h005);
        rd(4'd2, d); chk("R2 mask after clear", d, 9'h0A0);
        wr(4'd1, '1);

        // R3 / R4: rising edge on line 1 with mask off, then on
        wr(4'd5, 9'h002); wr(4'd9, 9'h002);
        pins_in[1] = 1'b1; cyc(6);
        rd(4'd3, d); chk("R4 rising edge sets status", d[1], 1);
        chk("R3 masked line irq low", irq[1], 0);
        wr(4'd0, 9'h002); #1;
        chk("R3 unmasked irq high", irq[1], 1);
        wr(4'd4, 9'h002); #1;
        chk("R3 irq drops with status", irq[1], 0);
        pins_in[1] = 1'b0; cyc(6);
        rd(4'd3, d); chk("R4 falling ignored with pol 1", d[1], 0);
        // R4: falling edge polarity
        wr(4'd9, 9'h000);
        pins_in[1] = 1'b1; cyc(6);
        rd(4'd3, d); chk("R4 rising ignored with pol 0", d[1], 0);
        pins_in[1] = 1'b0; cyc(6);
        rd(4'd3, d); chk("R4 falling edge sets status", d[1], 1);
        clear_cfg();

        // R5 / R6: level-high line 0
        wr(4'd5, 9'h001); wr(4'd8, 9'h001); wr(4'd9, 9'h001);
        pins_in[0] = 1'b1; cyc(6);
        wr(4'd4, 9'h001);
        rd(4'd3, d); chk("R5 level persists after clear", d[0], 1);
        chk("R6 clear with same-cycle event keeps bit", d[0], 1);
        pins_in[0] = 1'b0; cyc(6);
        wr(4'd4, 9'h001);
        rd(4'd3, d); chk("R6 clear without event", d[0], 0);
        clear_cfg();

        // R7: filter on line 2, rising edge
        wr(4'd5, 9'h004); wr(4'd9, 9'h004); wr(4'd10, 9'h004);
        pins_in[2] = 1'b1; cyc(2); pins_in[2] = 1'b0; cyc(10);
        rd(4'd3, d); chk("R7 2-cycle pulse rejected", d[2], 0);
        pins_in[2] = 1'b1; cyc(5); pins_in[2] = 1'b0; cyc(10);
        rd(4'd3, d); chk("R7 5-cycle pulse accepted", d[2], 1);
        clear_cfg();

        // R8: disabled line ignores pin
        wr(4'd5, 9'h00C); wr(4'd6, 9'h004); wr(4'd9, 9'h004);
        rd(4'd7, d); chk("R8 enabled set readback", d, 9'h008);
        pins_in[2] = 1'b1; cyc(6); pins_in[2] = 1'b0; cyc(6);
        rd(4'd3, d); chk("R8 disabled line no status", d[2], 0);
        wr(4'd5, 9'h004);
        pins_in[2] = 1'b1; cyc(6);
        rd(4'd3, d); chk("R8 enabled line sets status", d[2], 1);
        clear_cfg();

        // R9: wake-only line 3
        wr(4'd5, 9'h008); wr(4'd9, 9'h008); wr(4'd12, 9'h008); wr(4'd0, 9'h008);
        seen = 1'b0;
        pins_in[3] = 1'b1;
        for (int k = 0; k < 8; k++) begin @(negedge clk); if (wake) seen = 1'b1; end
        chk("R9 wake pulse seen", seen, 1);
        chk("R9 wake pulse ends", wake, 0);
        rd(4'd3, d); chk("R9 no status", d[3], 0);
        chk("R9 no irq", irq[3], 0);
        clear_cfg();

        // R10: asynchronous wake on line 5, checked before any clock edge
        wr(4'd5, 9'h020); wr(4'd9, 9'h020); wr(4'd11, 9'h020);
        #3 pins_in[5] = 1'b1; #1;
        chk("R10 async wake without clock edge", wake, 1);
        pins_in[5] = 1'b0; #1;
        chk("R10 async wake released", wake, 0);
        clear_cfg();

        // R11: NMI line, mask cannot block it
        wr(4'd5, 9'h100); wr(4'd9, 9'h100); wr(4'd1, '1);
        nmi_pin = 1'b1; cyc(6);
        chk("R11 nmi raised with no mask", nmi, 1);
        chk("R11 no general irq", irq, 0);
        wr(4'd4, 9'h100); #1;
        chk("R11 nmi cleared", nmi, 0);
        clear_cfg();

        // R3 / R4 / R5: constrained random single-line patterns
        wr(4'd5, '1);
        for (int it = 0; it < 30; it++) begin
            int ln;
            bit lv, pl, o, n, e;
            logic [NL-1:0] ms, mc;
            ln = int'($urandom % NL);
            lv = 1'($urandom); pl = 1'($urandom);
            o = 1'($urandom); n = 1'($urandom);
            ms = NL'($urandom); mc = NL'($urandom);
            wr(4'd0, {1'b0, ms}); m_mask = m_mask | ms;
            wr(4'd1, {1'b0, mc}); m_mask = m_mask & ~mc;
            rd(4'd2, d); chk("R2 random mask", d, {1'b0, m_mask});
            m_lvl[ln] = lv; m_pol[ln] = pl;
            wr(4'd8, m_lvl); wr(4'd9, m_pol);
            pins_in[ln] = o; cyc(6);
            wr(4'd4, '1);
            pins_in[ln] = n; cyc(6);
            e = exp_stat(lv, pl, o, n);
            rd(4'd3, d);
            chk($sformatf("R4/R5 random line %0d lvl %0d pol %0d %0d->%0d", ln, lv, pl, o, n), d[ln], e);
            chk("R3 random irq", irq[ln], e & m_mask[ln]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule